// File: doc/BRIEF.md
# UART Register Front End

This block is the software-visible face of a serial port. A processor reaches it through a 32-bit register bus addressed by word offset. Received characters arrive on a byte-stream input with a valid/ready handshake and a separate break strobe. Characters that software writes for transmission leave on a byte-stream output. Baud generation and bit-level serialization sit outside the block and connect through these two streams.

Receive data is held in a single-entry buffer. Status bits report whether the buffer holds a character and whether the transmit side can take another byte. One interrupt line is the OR over the bitwise AND of status word 1 and control word 1. Each enable therefore sits at the same bit position as the status flag it unmasks.

A break on the line is stored in the buffer as the code 0x400 and is flagged in the same way as any other received character. Bus reads are combinational on `busAddr`. Side effects, namely draining the receive buffer, take effect at the clock edge on which `busRdEn` is high.

Top module: `uart_reg_front`

## Requirements
- R1: After reset, the registers read as follows: word 0x25 = 0x00002000, word 0x26 = 0x00004008, word 0x20 = 0x00002200, word 0x2D = 0x00000020, and receive data at word 0x00 = 0x0000FFFF (buffer all ones, RX_W=16). `irq` is high and `rxReady` is high.
- R2: While receiver ready is clear, a cycle with `rxValid` high stores `rxData` zero-extended. It also sets receiver ready (word 0x25 bit 9) and receive data ready (word 0x26 bit 0), and clears receive empty (word 0x2D bit 5). `rxReady` is always the inverse of receiver ready.
- R3: While receiver ready is set, `rxValid` and `rxBreak` are ignored and the stored character is unchanged.
- R4: A read of word 0x00 returns the buffer. At that edge it clears receiver ready and receive data ready, and sets receive empty.
- R5: An `rxBreak` pulse accepted while receiver ready is clear stores 0x400 and raises the same flags as a character. A break takes precedence over `rxValid` in the same cycle.
- R6: A write to word 0x20 stores the full 32-bit value, which reads back unchanged. `irq` is high exactly when (word 0x25 AND word 0x20) is nonzero.
- R7: A write to word 0x10 presents its low byte on `txData` with `txValid` high from the next cycle. The byte is held stable until a cycle with `txReady` high takes it.
- R8: While a transmit byte is held, transmitter ready (word 0x25 bit 13), transmit empty (word 0x26 bit 14) and transmit complete (word 0x26 bit 3) read 0, and transmit full (word 0x2D bit 4) reads 1. A further write to word 0x10 in that time is ignored.
- R9: Words 0x21 to 0x24 read as zero. Writes to them and to words 0x25 and 0x26 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 6 | Word offset of the register access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (drains receive data at word 0x00) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` |
| rxValid | input | 1 | Received character valid |
| rxData | input | 8 | Received character |
| rxBreak | input | 1 | Break detected on the line |
| rxReady | output | 1 | Receive buffer can accept |
| txValid | output | 1 | Transmit byte valid |
| txData | output | 8 | Transmit byte |
| txReady | input | 1 | Downstream takes the transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
The two flags in the control half, buffer-full and transmit-held, drive every status word, both stream handshakes and the interrupt. A wrong flag therefore shows at the ports on the very next cycle: `rxReady` takes the wrong value, a status read disagrees, or `irq` tracks the wrong mask. A corrupted buffer or holding register stays hidden until the next read of word 0x00 or the next byte that leaves on `txData`. For that reason every scenario ends by draining what it stored.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int ADDR_W = 6;

  // word offsets decoded on the register bus
  localparam logic [ADDR_W-1:0] OFS_RXDATA  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_TXDATA  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_CTRL1   = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_STAT1   = 6'h25;
  localparam logic [ADDR_W-1:0] OFS_STAT2   = 6'h26;
  localparam logic [ADDR_W-1:0] OFS_TEST    = 6'h2D;

  // status / enable bit positions
  localparam int BIT_TXRDY   = 13;  // word 1: transmitter ready (and its enable)
  localparam int BIT_RXRDY   = 9;   // word 1: receiver ready (and its enable)
  localparam int BIT_TXEMPTY = 14;  // word 2
  localparam int BIT_TXDONE  = 3;   // word 2
  localparam int BIT_RXAVAIL = 0;   // word 2
  localparam int BIT_TXFULL  = 4;   // test word
  localparam int BIT_RXEMPTY = 5;   // test word

  localparam int BREAK_CODE = 'h400;

  typedef struct packed {
    logic loadRx;
    logic loadBreak;
    logic readRx;
    logic loadTx;
    logic txTaken;
    logic writeCtrl1;
  } strobe_t;
endpackage

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              rxValid,
  input  logic              rxBreak,
  input  logic              txReady,
  output logic              rxReady,
  output logic              rxFull,
  output logic              holdValid,
  output strobe_t           strobes
);
  always_comb begin
    strobes            = '0;
    strobes.loadBreak  = !rxFull && rxBreak;
    strobes.loadRx     = !rxFull && rxValid && !rxBreak;
    strobes.readRx     = busRdEn && (busAddr == OFS_RXDATA);
    strobes.loadTx     = busWrEn && (busAddr == OFS_TXDATA) && !holdValid;
    strobes.txTaken    = holdValid && txReady;
    strobes.writeCtrl1 = busWrEn && (busAddr == OFS_CTRL1);
  end

  assign rxReady = !rxFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull    <= 1'b0;
      holdValid <= 1'b0;
    end else begin
      if (strobes.loadRx || strobes.loadBreak) rxFull <= 1'b1;
      else if (strobes.readRx)                 rxFull <= 1'b0;
      if (strobes.loadTx)       holdValid <= 1'b1;
      else if (strobes.txTaken) holdValid <= 1'b0;
    end
  end

  // R2: an offered character while ready is always taken
  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady) |=> rxFull);
  // R3: a full buffer only empties through a data read
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !(busRdEn && busAddr == OFS_RXDATA)) |=> rxFull);
  // R7: a held byte stays until the sink takes it
  p_hold_stays_r7: assert property (@(posedge clk) disable iff (!rstN)
    (holdValid && !txReady) |=> holdValid);
endmodule

// File: rtl/uart_reg_data.sv
module uart_reg_data
  import uart_reg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RX_W   = 16,
  parameter int BYTE_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxFull,
  input  logic              holdValid,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] rxWord,
  output logic [DATA_W-1:0] stat1Word,
  output logic [DATA_W-1:0] ctrl1Word,
  output logic [BYTE_W-1:0] txData
);
  localparam logic [DATA_W-1:0] CTRL1_RESET =
    (DATA_W'(1) << BIT_TXRDY) | (DATA_W'(1) << BIT_RXRDY);
  localparam logic [RX_W-1:0] BREAK_VAL = RX_W'(BREAK_CODE);

  logic [RX_W-1:0]   rxBuf;
  logic [DATA_W-1:0] ctrl1Reg;
  logic [BYTE_W-1:0] holdReg;
  logic [DATA_W-1:0] stat2Word;
  logic [DATA_W-1:0] testWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf    <= '1;
      ctrl1Reg <= CTRL1_RESET;
      holdReg  <= '0;
    end else begin
      if (strobes.loadBreak)   rxBuf <= BREAK_VAL;
      else if (strobes.loadRx) rxBuf <= RX_W'(rxData);
      if (strobes.writeCtrl1)  ctrl1Reg <= busWdata;
      if (strobes.loadTx)      holdReg <= busWdata[BYTE_W-1:0];
    end
  end

  always_comb begin
    stat1Word = '0;
    stat1Word[BIT_TXRDY] = !holdValid;
    stat1Word[BIT_RXRDY] = rxFull;
    stat2Word = '0;
    stat2Word[BIT_TXEMPTY] = !holdValid;
    stat2Word[BIT_TXDONE]  = !holdValid;
    stat2Word[BIT_RXAVAIL] = rxFull;
    testWord = '0;
    testWord[BIT_TXFULL]  = holdValid;
    testWord[BIT_RXEMPTY] = !rxFull;
  end

  assign rxWord    = DATA_W'(rxBuf);
  assign ctrl1Word = ctrl1Reg;
  assign txData    = holdReg;

  always_comb begin
    unique case (busAddr)
      OFS_RXDATA: busRdata = rxWord;
      OFS_CTRL1:  busRdata = ctrl1Reg;
      OFS_STAT1:  busRdata = stat1Word;
      OFS_STAT2:  busRdata = stat2Word;
      OFS_TEST:   busRdata = testWord;
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_reg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RX_W   = 16,
  parameter int BYTE_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxBreak,
  output logic              rxReady,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  input  logic              txReady,
  output logic              irq
);
  strobe_t           strobes;
  logic              rxFull;
  logic              holdValid;
  logic [DATA_W-1:0] rxWord;
  logic [DATA_W-1:0] stat1Word;
  logic [DATA_W-1:0] ctrl1Word;

  uart_reg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .rxValid(rxValid), .rxBreak(rxBreak),
    .txReady(txReady), .rxReady(rxReady), .rxFull(rxFull),
    .holdValid(holdValid), .strobes(strobes)
  );

  uart_reg_data #(.DATA_W(DATA_W), .RX_W(RX_W), .BYTE_W(BYTE_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr),
    .busWdata(busWdata), .rxData(rxData), .rxFull(rxFull),
    .holdValid(holdValid), .busRdata(busRdata), .rxWord(rxWord),
    .stat1Word(stat1Word), .ctrl1Word(ctrl1Word), .txData(txData)
  );

  assign txValid = holdValid;
  assign irq     = |(stat1Word & ctrl1Word);

  // R5: an accepted break leaves the break code in the buffer
  p_break_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxBreak && rxReady) |=> (rxWord == DATA_W'(BREAK_CODE)));
  // R6: no interrupt without at least one enable bit
  p_irq_enable_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ctrl1Word[BIT_TXRDY] || ctrl1Word[BIT_RXRDY]));
  // R7: an offered transmit byte does not change while it waits
  p_tx_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData)));
  // R8: a transmit write while busy leaves the held byte alone
  p_tx_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_TXDATA && txValid && !txReady) |=> $stable(txData));
endmodule

// File: tb/uart_reg_front_test.sv
module uart_reg_front_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxBreak = 1'b0;
  logic        rxReady;
  logic        txValid;
  logic [7:0]  txData;
  logic        txReady = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  uart_reg_front uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWdata(busWdata), .busRdata(busRdata),
    .rxValid(rxValid), .rxData(rxData), .rxBreak(rxBreak), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .txReady(txReady), .irq(irq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [5:0] a, logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0; #1;
  endtask

  task automatic busRead(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRdEn = 1'b1; #1; d = busRdata;
    @(negedge clk); busRdEn = 1'b0; #1;
  endtask

  task automatic rxPush(logic [7:0] d, logic brk);
    @(negedge clk); rxValid = 1'b1; rxData = d; rxBreak = brk;
    @(negedge clk); rxValid = 1'b0; rxBreak = 1'b0; #1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq", 32'(irq), 32'd1);
    check("R1 rxReady", 32'(rxReady), 32'd1);
    check("R1 txValid", 32'(txValid), 32'd0);
    busRead(6'h25, v); check("R1 stat1", v, 32'h2000);
    busRead(6'h26, v); check("R1 stat2", v, 32'h4008);
    busRead(6'h20, v); check("R1 ctrl1", v, 32'h2200);
    busRead(6'h2D, v); check("R1 test", v, 32'h20);
    busRead(6'h00, v); check("R1 rx buffer", v, 32'hFFFF);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    busWrite(6'h20, 32'h200);
    check("R6 irq rx-only mask idle", 32'(irq), 32'd0);
    busRead(6'h20, v); check("R6 ctrl1 readback", v, 32'h200);
    rxPush(8'h3C, 1'b0);
    check("R6 irq on rx ready", 32'(irq), 32'd1);
    busRead(6'h00, v); check("R4 rx data", v, 32'h3C);
    check("R6 irq after drain", 32'(irq), 32'd0);
    busWrite(6'h20, 32'h2000);
    check("R6 irq tx-ready mask", 32'(irq), 32'd1);
    busWrite(6'h20, 32'hFFFF_DDFF);
    check("R6 irq other bits only", 32'(irq), 32'd0);
    busRead(6'h20, v); check("R6 ctrl1 full width", v, 32'hFFFF_DDFF);
    busWrite(6'h20, 32'h2200);
  endtask

  task automatic t_rx;
    logic [31:0] v;
    rxPush(8'h5A, 1'b0);
    check("R2 rxReady low", 32'(rxReady), 32'd0);
    busRead(6'h25, v); check("R2 stat1", v, 32'h2200);
    busRead(6'h26, v); check("R2 stat2", v, 32'h4009);
    busRead(6'h2D, v); check("R2 test", v, 32'h0);
    @(negedge clk); rxValid = 1'b1; rxData = 8'hA5;
    @(negedge clk); @(negedge clk); rxValid = 1'b0; #1;
    check("R3 still full", 32'(rxReady), 32'd0);
    busRead(6'h00, v); check("R3 buffer kept", v, 32'h5A);
    check("R4 rxReady restored", 32'(rxReady), 32'd1);
    busRead(6'h25, v); check("R4 stat1", v, 32'h2000);
    busRead(6'h26, v); check("R4 stat2", v, 32'h4008);
    busRead(6'h2D, v); check("R4 test", v, 32'h20);
  endtask

  task automatic t_break;
    logic [31:0] v;
    rxPush(8'h11, 1'b1);
    busRead(6'h25, v); check("R5 stat1 after break", v, 32'h2200);
    rxPush(8'h00, 1'b1);
    busRead(6'h00, v); check("R5 break code", v, 32'h400);
    check("R5 drained", 32'(rxReady), 32'd1);
  endtask

  task automatic t_tx;
    logic [31:0] v;
    txReady = 1'b0;
    busWrite(6'h10, 32'h1234_56C3);
    check("R7 txValid", 32'(txValid), 32'd1);
    check("R7 txData", 32'(txData), 32'hC3);
    busRead(6'h25, v); check("R8 stat1 busy", v, 32'h0);
    busRead(6'h26, v); check("R8 stat2 busy", v, 32'h0);
    busRead(6'h2D, v); check("R8 test busy", v, 32'h30);
    busWrite(6'h10, 32'h77);
    check("R8 second write ignored", 32'(txData), 32'hC3);
    @(negedge clk); txReady = 1'b1;
    @(negedge clk); txReady = 1'b0; #1;
    check("R7 taken", 32'(txValid), 32'd0);
    busRead(6'h25, v); check("R8 stat1 idle", v, 32'h2000);
    busWrite(6'h10, 32'h99);
    check("R7 next byte", 32'(txData), 32'h99);
    @(negedge clk); txReady = 1'b1;
    @(negedge clk); txReady = 1'b0; #1;
    check("R7 next taken", 32'(txValid), 32'd0);
  endtask

  task automatic t_unused;
    logic [31:0] v;
    for (int a = 6'h21; a <= 6'h26; a++) busWrite(6'(a), 32'hFFFF_FFFF);
    for (int a = 6'h21; a <= 6'h24; a++) begin
      busRead(6'(a), v); check("R9 unused reads zero", v, 32'h0);
    end
    busRead(6'h25, v); check("R9 stat1 unchanged", v, 32'h2000);
    busRead(6'h26, v); check("R9 stat2 unchanged", v, 32'h4008);
    busRead(6'h20, v); check("R9 ctrl1 unchanged", v, 32'h2200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1; #1;
    t_reset();
    t_irq();
    t_rx();
    t_break();
    t_tx();
    t_unused();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule